// File: doc/BRIEF.md
# Flash Write-Control Register Interlock

This block is the register front end that software uses to start, suspend and resume program and erase operations on an embedded flash with two modules. The second module has two independently gated banks. Software picks an operation (word program, double-word program, sector erase or protection set) and a target module, loads an address and a data word, and then writes the start bit. From that point until the operation ends, the block locks the flash control, data, address and error registers. While the second module is the target, it also marks both of that module's banks busy. A locked or busy access returns invalid data and raises a trap carrying a fixed code.

A small state machine sequences each operation. The four states are `ST_IDLE`, `ST_CHECK`, `ST_RUN` and `ST_SUSP`. The transitions are:
- start (`ST_IDLE`→`ST_CHECK`), taken on a control write with the start bit set;
- accept (`ST_CHECK`→`ST_RUN`), which also pulses the engine start;
- reject (`ST_CHECK`→`ST_IDLE`), taken for a protection set whose address is out of range;
- finish (`ST_RUN`→`ST_IDLE`), on the engine's done;
- pause (`ST_RUN`→`ST_SUSP`);
- continue (`ST_SUSP`→`ST_RUN`).

The program/erase engine itself is outside the block. It is reached through single-cycle start, suspend and resume strobes and a done input.

Register map (3-bit `reg_addr`):
- 0 is status: bit 0 is lock, bits 2:1 are the busy flags of banks 0 and 1. It is always readable.
- 1 is control: bit 15 start, 14 suspend, 13 word program, 12 double-word program, 11 sector erase, 8 protection set, 0 module select.
- 2 is the data word.
- 3 and 4 are the low and high address halves.
- 5 is the error register, with the sequence-error flag in bit 0.
- Addresses 6 and 7 read as zero.

Top module: `flash_wr_interlock`

## Requirements
- R1: After reset, and after an asynchronous reset that arrives during an operation, status and control read 0x0000 and no engine strobe is active.
- R2: A control write with bit 15 set, made while unlocked, sets lock in the next cycle. Busy bits 2:1 become 11 if module select (bit 0) was 1, and stay 00 if it was 0.
- R3: While locked, a read of registers 1 to 5 returns 0xFFFF, asserts `trap` and drives `trap_code` to 0x009B. A status read never traps.
- R4: While locked, writes to the data, address and error registers are discarded, so the earlier values read back once lock clears.
- R5: A bank read of a busy bank is refused (`bank_rd_en` low) and traps, and a bank write to it is dropped. Banks that are not busy pass through.
- R6: An accepted operation pulses `eng_start` for exactly one cycle. Lock spans engine length plus two cycles. The done input clears lock and busy in the next cycle and self-clears start, select and operation bits.
- R7: Writing control with bit 14 set during a run pulses `eng_suspend`. Busy then clears while lock stays. Writing with bit 14 clear pulses `eng_resume` and sets busy again. A write with bit 14 set while suspended does not resume.
- R8: A protection set (bit 8) whose 32-bit address lies outside 0x000EDFB0 to 0x000EDFBF does not pulse `eng_start`. Lock is released after one cycle and error bit 0 is set. Both bounds are accepted.
- R9: Control bits 13, 12, 11, 8 and 0 read back as written while idle. The suspend bit cannot be set by an idle write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| bank_sel | input | 1 | Bank of the second module being accessed |
| bank_rd | input | 1 | Bank read request |
| bank_wr | input | 1 | Bank write request |
| bank_rd_en | output | 1 | Read allowed through to the array |
| bank_wr_en | output | 1 | Write allowed through to the array |
| trap | output | 1 | Invalid-access trap |
| trap_code | output | 16 | Trap code, 0x009B while trap is high |
| eng_start | output | 1 | Engine start strobe |
| eng_suspend | output | 1 | Engine suspend strobe |
| eng_resume | output | 1 | Engine resume strobe |
| eng_done | input | 1 | Engine completion |
| eng_module | output | 1 | Target module |
| eng_op | output | 4 | {word, double-word, erase, protection} |
| eng_addr | output | 32 | Target address |
| eng_data | output | 16 | Data word |

## Verification
The hardest state to reach is a suspended operation on the second module. In that state lock must stay up while both busy flags drop, and a wrong-polarity control write must not resume. Getting there requires a running engine that honours the suspend strobe and freezes its own count. The bench therefore runs a behavioural engine with a settable length that pauses on `eng_suspend` and continues on `eng_resume`. It places the suspend write a few cycles into a long run, probes bank access and a false resume while suspended, and then resumes and polls status until the operation finishes. The range check is driven from a vector table that straddles both bounds and flips high address bits.

// File: rtl/fwi_pkg.sv
package fwi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_RUN   = 2'd2,
        ST_SUSP  = 2'd3
    } fwi_state_t;

    localparam logic [2:0] RA_STAT = 3'd0;
    localparam logic [2:0] RA_CTL  = 3'd1;
    localparam logic [2:0] RA_DATA = 3'd2;
    localparam logic [2:0] RA_ADRL = 3'd3;
    localparam logic [2:0] RA_ADRH = 3'd4;
    localparam logic [2:0] RA_ERR  = 3'd5;

    localparam int CB_START = 15;
    localparam int CB_SUSP  = 14;
    localparam int CB_WP    = 13;
    localparam int CB_DWP   = 12;
    localparam int CB_SE    = 11;
    localparam int CB_PROT  = 8;
    localparam int CB_MOD   = 0;
endpackage

// File: rtl/fwi_range_chk.sv
module fwi_range_chk #(
    parameter int          AW = 32,
    parameter logic [31:0] LO = 32'h000E_DFB0,
    parameter logic [31:0] HI = 32'h000E_DFBF
) (
    input  logic [AW-1:0] addr,
    output logic          in_range
);
    always_comb begin
        in_range = (addr >= AW'(LO)) && (addr <= AW'(HI));
    end
endmodule

// File: rtl/fwi_seq_fsm.sv
module fwi_seq_fsm
    import fwi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       susp_req,
    input  logic       resume_req,
    input  logic       eng_done,
    input  logic       prot_sel,
    input  logic       range_ok,
    output fwi_state_t st,
    output logic       lock,
    output logic       eng_start,
    output logic       eng_suspend,
    output logic       eng_resume,
    output logic       seq_fail,
    output logic       op_end
);
    fwi_state_t nxt;
    logic       seq_bad;

    assign seq_bad = prot_sel && !range_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (start_req) nxt = ST_CHECK;
            ST_CHECK: nxt = seq_bad ? ST_IDLE : ST_RUN;
            ST_RUN: begin
                if (eng_done)      nxt = ST_IDLE;
                else if (susp_req) nxt = ST_SUSP;
            end
            ST_SUSP:  if (resume_req) nxt = ST_RUN;
        endcase
    end

    always_comb begin
        lock        = (st != ST_IDLE);
        eng_start   = (st == ST_CHECK) && !seq_bad;
        seq_fail    = (st == ST_CHECK) && seq_bad;
        eng_suspend = (st == ST_RUN) && susp_req && !eng_done;
        eng_resume  = (st == ST_SUSP) && resume_req;
        op_end      = seq_fail || ((st == ST_RUN) && eng_done);
    end
endmodule

// File: rtl/fwi_regs.sv
module fwi_regs
    import fwi_pkg::*;
#(
    parameter int          NBANK    = 2,
    parameter logic [15:0] BAD_DATA = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [15:0]      reg_wdata,
    input  logic             lock,
    input  fwi_state_t       st,
    input  logic [NBANK-1:0] busy,
    input  logic             seq_fail,
    input  logic             op_end,
    output logic [15:0]      reg_rdata,
    output logic             trap_reg,
    output logic             start_req,
    output logic             susp_req,
    output logic             resume_req,
    output logic             mod_sel,
    output logic             prot_sel,
    output logic [2:0]       op_bits,
    output logic [15:0]      data_q,
    output logic [31:0]      addr_q
);
    logic        start_q, susp_q, err_q;
    logic [15:0] adrl_q, adrh_q;
    logic        ctl_wr, open_wr, guarded;

    assign ctl_wr     = reg_wr && (reg_addr == RA_CTL);
    assign open_wr    = reg_wr && !lock;
    assign start_req  = ctl_wr && !lock && reg_wdata[CB_START];
    assign susp_req   = ctl_wr && (st == ST_RUN) && reg_wdata[CB_SUSP];
    assign resume_req = ctl_wr && (st == ST_SUSP) && !reg_wdata[CB_SUSP];
    assign addr_q     = {adrh_q, adrl_q};
    assign guarded    = (reg_addr >= RA_CTL) && (reg_addr <= RA_ERR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q  <= 1'b0;
            susp_q   <= 1'b0;
            op_bits  <= '0;
            prot_sel <= 1'b0;
            mod_sel  <= 1'b0;
        end else if (op_end) begin
            start_q  <= 1'b0;
            susp_q   <= 1'b0;
            op_bits  <= '0;
            prot_sel <= 1'b0;
            mod_sel  <= 1'b0;
        end else if (ctl_wr && !lock) begin
            start_q  <= reg_wdata[CB_START];
            susp_q   <= 1'b0;
            op_bits  <= {reg_wdata[CB_WP], reg_wdata[CB_DWP], reg_wdata[CB_SE]};
            prot_sel <= reg_wdata[CB_PROT];
            mod_sel  <= reg_wdata[CB_MOD];
        end else if (susp_req) begin
            susp_q   <= 1'b1;
        end else if (resume_req) begin
            susp_q   <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            adrl_q <= '0;
            adrh_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (open_wr && reg_addr == RA_DATA) data_q <= reg_wdata;
            if (open_wr && reg_addr == RA_ADRL) adrl_q <= reg_wdata;
            if (open_wr && reg_addr == RA_ADRH) adrh_q <= reg_wdata;
            if (seq_fail)
                err_q <= 1'b1;
            else if (open_wr && reg_addr == RA_ERR)
                err_q <= reg_wdata[0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        trap_reg  = 1'b0;
        if (reg_rd) begin
            if (lock && guarded) begin
                reg_rdata = BAD_DATA;
                trap_reg  = 1'b1;
            end else begin
                unique case (reg_addr)
                    RA_STAT: reg_rdata = {{(15-NBANK){1'b0}}, busy, lock};
                    RA_CTL:  reg_rdata = {start_q, susp_q, op_bits, 2'b00,
                                          prot_sel, 7'b0, mod_sel};
                    RA_DATA: reg_rdata = data_q;
                    RA_ADRL: reg_rdata = adrl_q;
                    RA_ADRH: reg_rdata = adrh_q;
                    RA_ERR:  reg_rdata = {15'b0, err_q};
                    default: reg_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/fwi_bank_gate.sv
module fwi_bank_gate #(
    parameter int NBANK = 2,
    parameter int BSW   = 1
) (
    input  logic [NBANK-1:0] busy,
    input  logic [BSW-1:0]   bank_sel,
    input  logic             bank_rd,
    input  logic             bank_wr,
    output logic             bank_rd_en,
    output logic             bank_wr_en,
    output logic             bank_trap
);
    logic [NBANK-1:0] hit;
    logic             sel_busy;

    for (genvar b = 0; b < NBANK; b++) begin : g_hit
        assign hit[b] = busy[b] && (bank_sel == BSW'(b));
    end

    assign sel_busy   = |hit;
    assign bank_rd_en = bank_rd && !sel_busy;
    assign bank_wr_en = bank_wr && !sel_busy;
    assign bank_trap  = bank_rd && sel_busy;
endmodule

// File: rtl/flash_wr_interlock.sv
module flash_wr_interlock
    import fwi_pkg::*;
#(
    parameter int          NBANK    = 2,
    parameter int          BSW      = 1,
    parameter logic [31:0] PROT_LO  = 32'h000E_DFB0,
    parameter logic [31:0] PROT_HI  = 32'h000E_DFBF,
    parameter logic [15:0] TRAP_ID  = 16'h009B,
    parameter logic [15:0] BAD_DATA = 16'hFFFF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     reg_addr,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [15:0]    reg_wdata,
    output logic [15:0]    reg_rdata,
    input  logic [BSW-1:0] bank_sel,
    input  logic           bank_rd,
    input  logic           bank_wr,
    output logic           bank_rd_en,
    output logic           bank_wr_en,
    output logic           trap,
    output logic [15:0]    trap_code,
    output logic           eng_start,
    output logic           eng_suspend,
    output logic           eng_resume,
    input  logic           eng_done,
    output logic           eng_module,
    output logic [3:0]     eng_op,
    output logic [31:0]    eng_addr,
    output logic [15:0]    eng_data
);
    fwi_state_t       st;
    logic             lock, seq_fail, op_end, range_ok;
    logic             start_req, susp_req, resume_req;
    logic             mod_sel, prot_sel, trap_reg, bank_trap;
    logic [2:0]       op_bits;
    logic [NBANK-1:0] busy;

    for (genvar b = 0; b < NBANK; b++) begin : g_busy
        assign busy[b] = mod_sel && ((st == ST_CHECK) || (st == ST_RUN));
    end

    fwi_range_chk #(.AW(32), .LO(PROT_LO), .HI(PROT_HI)) u_range (
        .addr(eng_addr), .in_range(range_ok)
    );

    fwi_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .susp_req(susp_req),
        .resume_req(resume_req), .eng_done(eng_done), .prot_sel(prot_sel),
        .range_ok(range_ok), .st(st), .lock(lock), .eng_start(eng_start),
        .eng_suspend(eng_suspend), .eng_resume(eng_resume),
        .seq_fail(seq_fail), .op_end(op_end)
    );

    fwi_regs #(.NBANK(NBANK), .BAD_DATA(BAD_DATA)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .lock(lock), .st(st),
        .busy(busy), .seq_fail(seq_fail), .op_end(op_end),
        .reg_rdata(reg_rdata), .trap_reg(trap_reg), .start_req(start_req),
        .susp_req(susp_req), .resume_req(resume_req), .mod_sel(mod_sel),
        .prot_sel(prot_sel), .op_bits(op_bits), .data_q(eng_data),
        .addr_q(eng_addr)
    );

    fwi_bank_gate #(.NBANK(NBANK), .BSW(BSW)) u_gate (
        .busy(busy), .bank_sel(bank_sel), .bank_rd(bank_rd), .bank_wr(bank_wr),
        .bank_rd_en(bank_rd_en), .bank_wr_en(bank_wr_en), .bank_trap(bank_trap)
    );

    assign trap       = trap_reg || bank_trap;
    assign trap_code  = trap ? TRAP_ID : 16'h0000;
    assign eng_module = mod_sel;
    assign eng_op     = {op_bits, prot_sel};
endmodule

// File: rtl/fwi_checker.sv
module fwi_checker
    import fwi_pkg::*;
#(
    parameter int NBANK = 2,
    parameter int BSW   = 1
) (
    input logic             clk,
    input logic             rst_n,
    input fwi_state_t       st,
    input logic             lock,
    input logic [NBANK-1:0] busy,
    input logic [2:0]       reg_addr,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic             start_bit,
    input logic [15:0]      reg_rdata,
    input logic             trap,
    input logic [BSW-1:0]   bank_sel,
    input logic             bank_rd,
    input logic             bank_rd_en,
    input logic             eng_start,
    input logic             eng_suspend,
    input logic             eng_resume,
    input logic             eng_done
);
    // R2
    start_sets_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_CTL && start_bit && !lock) |=> lock);
    // R3
    locked_read_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && reg_rd && reg_addr >= RA_CTL && reg_addr <= RA_ERR)
            |-> (trap && reg_rdata == 16'hFFFF));
    // R3
    status_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == RA_STAT && !bank_rd) |-> !trap);
    // R5
    busy_bank_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_rd && busy[bank_sel]) |-> (!bank_rd_en && trap));
    // R6
    start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);
    // R6
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && eng_done) |=> (!lock && busy == '0));
    // R7
    suspend_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_suspend |=> (lock && busy == '0));
    // R7
    resume_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_resume |=> (st == ST_RUN));
    // R8
    reject_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CHECK && !eng_start) |=> !lock);
endmodule

bind flash_wr_interlock fwi_checker #(.NBANK(NBANK), .BSW(BSW)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .lock(lock), .busy(busy),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .start_bit(reg_wdata[15]), .reg_rdata(reg_rdata), .trap(trap),
    .bank_sel(bank_sel), .bank_rd(bank_rd), .bank_rd_en(bank_rd_en),
    .eng_start(eng_start), .eng_suspend(eng_suspend),
    .eng_resume(eng_resume), .eng_done(eng_done)
);

// File: tb/flash_wr_interlock_test.sv
module flash_wr_interlock_test;
    localparam logic [2:0] A_STAT = 3'd0, A_CTL = 3'd1, A_DATA = 3'd2,
                           A_ADRL = 3'd3, A_ADRH = 3'd4, A_ERR = 3'd5;

    // {accept, 32-bit address}
    localparam logic [32:0] PVEC [7] = '{
        {1'b0, 32'h000E_DFAF}, {1'b1, 32'h000E_DFB0}, {1'b1, 32'h000E_DFB7},
        {1'b1, 32'h000E_DFBF}, {1'b0, 32'h000E_DFC0}, {1'b0, 32'h001E_DFB0},
        {1'b0, 32'h000E_DEB0}
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic        bank_sel = 1'b0, bank_rd = 1'b0, bank_wr = 1'b0;
    logic        bank_rd_en, bank_wr_en, trap;
    logic [15:0] trap_code, eng_data;
    logic        eng_start, eng_suspend, eng_resume, eng_module;
    logic        eng_done = 1'b0;
    logic [3:0]  eng_op;
    logic [31:0] eng_addr;

    flash_wr_interlock uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bank_sel(bank_sel), .bank_rd(bank_rd), .bank_wr(bank_wr),
        .bank_rd_en(bank_rd_en), .bank_wr_en(bank_wr_en), .trap(trap),
        .trap_code(trap_code), .eng_start(eng_start),
        .eng_suspend(eng_suspend), .eng_resume(eng_resume),
        .eng_done(eng_done), .eng_module(eng_module), .eng_op(eng_op),
        .eng_addr(eng_addr), .eng_data(eng_data)
    );

    // behavioural engine with settable length
    int eng_len = 5;
    int cnt = 0;
    bit active = 1'b0, paused = 1'b0;
    always @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0; paused <= 1'b0; cnt <= 0; eng_done <= 1'b0;
        end else begin
            eng_done <= 1'b0;
            if (eng_start) begin
                active <= 1'b1; paused <= 1'b0; cnt <= eng_len;
            end else if (eng_suspend) paused <= 1'b1;
            else if (eng_resume) paused <= 1'b0;
            else if (active && !paused) begin
                if (cnt == 1) begin eng_done <= 1'b1; active <= 1'b0; end
                cnt <= cnt - 1;
            end
        end
    end

    int  n_chk = 0, n_fail = 0;
    bit  finished = 1'b0;
    logic s_start, s_susp, s_res;
    logic [15:0] d, tc;
    logic t, er, ew;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        #2;
        s_start = eng_start; s_susp = eng_suspend; s_res = eng_resume;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v,
                      output logic tr, output logic [15:0] code);
        reg_addr = a; reg_rd = 1'b1;
        #2;
        v = reg_rdata; tr = trap; code = trap_code;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic bk(input logic sel, input logic r, input logic w,
                      output logic en_r, output logic en_w, output logic tr);
        bank_sel = sel; bank_rd = r; bank_wr = w;
        #2;
        en_r = bank_rd_en; en_w = bank_wr_en; tr = trap;
        @(posedge clk); #1;
        bank_rd = 1'b0; bank_wr = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        logic [15:0] v; logic tr; logic [15:0] c;
        bit gone = 1'b0;
        n = 0;
        for (int i = 0; i < 2000 && !gone; i++) begin
            rd(A_STAT, v, tr, c);
            if (v[0] == 1'b0) gone = 1'b1;
            else n++;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        rd(A_STAT, d, t, tc); chk("R1 status", d, 16'h0000);
        rd(A_CTL, d, t, tc);  chk("R1 control", d, 16'h0000);
        chk("R1 strobes", {eng_start, eng_suspend, eng_resume}, 3'b000);

        // R9 field layout
        wr(A_CTL, 16'h3800); rd(A_CTL, d, t, tc); chk("R9 op bits", d, 16'h3800);
        wr(A_CTL, 16'h0101); rd(A_CTL, d, t, tc); chk("R9 prot/mod", d, 16'h0101);
        wr(A_CTL, 16'h4000); rd(A_CTL, d, t, tc); chk("R9 idle suspend masked", d, 16'h0000);

        wr(A_DATA, 16'h1234); wr(A_ADRL, 16'h5678); wr(A_ADRH, 16'h0012);

        // module 0 run
        eng_len = 8;
        wr(A_CTL, 16'hA000);
        chk("R6 start pulse", eng_start, 1'b1);
        chk("R6 engine fields", {eng_module, eng_op, eng_addr, eng_data},
            {1'b0, 4'b1000, 32'h0012_5678, 16'h1234});
        rd(A_DATA, d, t, tc);
        chk("R3 locked read data", d, 16'hFFFF);
        chk("R3 trap and code", {t, tc}, {1'b1, 16'h009B});
        wr(A_DATA, 16'hBEEF);
        rd(A_STAT, d, t, tc); chk("R2 module 0 lock without busy", d, 16'h0001);
        chk("R3 status read no trap", t, 1'b0);
        bk(1'b0, 1'b1, 1'b0, er, ew, t); chk("R5 module 0 bank open", {er, t}, 2'b10);
        wait_idle(n);
        rd(A_DATA, d, t, tc); chk("R4 locked write discarded", d, 16'h1234);
        rd(A_CTL, d, t, tc);  chk("R6 control self-clear", d, 16'h0000);

        // R6 lock span for length 5
        eng_len = 5;
        wr(A_CTL, 16'h8001);
        wait_idle(n);
        chk("R6 lock span", n, 7);

        // R5 bank gating on module 1
        eng_len = 10;
        wr(A_CTL, 16'h8001);
        bk(1'b0, 1'b1, 1'b0, er, ew, t); chk("R5 busy bank0 read", {er, t}, 2'b01);
        bk(1'b1, 1'b0, 1'b1, er, ew, t); chk("R5 busy bank1 write", ew, 1'b0);
        wait_idle(n);
        bk(1'b1, 1'b1, 1'b1, er, ew, t); chk("R5 idle bank open", {er, ew, t}, 3'b110);

        // R7 suspend and resume
        eng_len = 20;
        wr(A_CTL, 16'h8001);
        step(3);
        wr(A_CTL, 16'hC001); chk("R7 suspend strobe", s_susp, 1'b1);
        rd(A_STAT, d, t, tc); chk("R7 suspended lock only", d, 16'h0001);
        bk(1'b0, 1'b1, 1'b0, er, ew, t); chk("R7 bank readable when suspended", {er, t}, 2'b10);
        rd(A_CTL, d, t, tc); chk("R7 control locked while suspended", t, 1'b1);
        wr(A_CTL, 16'hC001); chk("R7 wrong polarity no resume", s_res, 1'b0);
        rd(A_STAT, d, t, tc); chk("R7 still suspended", d, 16'h0001);
        step(10);
        rd(A_STAT, d, t, tc); chk("R7 engine paused", d, 16'h0001);
        wr(A_CTL, 16'h8001); chk("R7 resume strobe", s_res, 1'b1);
        rd(A_STAT, d, t, tc); chk("R7 busy again", d, 16'h0007);
        wait_idle(n);
        rd(A_CTL, d, t, tc); chk("R6 self-clear after resume", d, 16'h0000);

        // R8 protection-set range table
        eng_len = 3;
        for (int i = 0; i < 7; i++) begin
            wr(A_ADRL, PVEC[i][15:0]);
            wr(A_ADRH, PVEC[i][31:16]);
            wr(A_CTL, 16'h8101);
            chk("R8 start gated by range", eng_start, PVEC[i][32]);
            rd(A_STAT, d, t, tc); chk("R2 check cycle lock and busy", d, 16'h0007);
            if (!PVEC[i][32]) begin
                rd(A_STAT, d, t, tc); chk("R8 lock released next cycle", d, 16'h0000);
            end
            wait_idle(n);
            rd(A_ERR, d, t, tc); chk("R8 error flag", d, {15'b0, !PVEC[i][32]});
            wr(A_ERR, 16'h0000);
        end

        // R4 error register protected while locked
        wr(A_ADRL, 16'h0000); wr(A_ADRH, 16'h0000);
        wr(A_CTL, 16'h8101);
        step(1);
        wr(A_ADRL, 16'hDFB0); wr(A_ADRH, 16'h000E);
        eng_len = 4;
        wr(A_CTL, 16'h8001);
        wr(A_ERR, 16'h0000);
        wait_idle(n);
        rd(A_ERR, d, t, tc); chk("R4 error write discarded", d, 16'h0001);
        wr(A_ERR, 16'h0000);
        rd(A_ERR, d, t, tc); chk("R4 error write when idle", d, 16'h0000);

        // R1 reset mid-operation
        eng_len = 30;
        wr(A_CTL, 16'h8001);
        step(2);
        rst_n = 1'b0;
        #1;
        rd(A_STAT, d, t, tc); chk("R1 reset mid-run status", d, 16'h0000);
        rst_n = 1'b1;
        step(1);
        rd(A_CTL, d, t, tc); chk("R1 reset mid-run control", d, 16'h0000);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule